// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a serial bit stream and turns it into characters. The stream is bit-synchronous: a bit strobe and a data bit arrive already aligned to the system clock. After reset the receiver hunts for a programmable sync pattern. It tests the pattern after every incoming bit. Once it sees two sync characters back to back on the same character grid, it declares itself active. From then on it cuts the stream into characters of the selected length on fixed boundaries.

Each completed character moves from the shift stage into a holding buffer. This double buffering gives software a full character time to read the previous character before it is lost. With each character the block reports a done flag, the even parity of the character and an overrun flag. Sync characters that arrive once the receiver is active can be discarded instead of delivered. A half-duplex mode freezes the receiver while request-to-send is asserted. A loopback select feeds the local transmitter's serial output into the receiver in place of the line.

Top module: `sync_char_rx`

## Requirements
- R1: The character length L comes from `len_sel` and `len_ext`. `len_sel` 0, 1, 2 and 3 give 6, 7, 8 and 8 bits, and `len_ext`=1 adds 4 (10, 11, 12). Only the low L bits of `sync_char` are used, and `rx_data` bits at L and above read as zero.
- R2: Bits arrive most significant first. While hunting, the last L received bits are compared with the sync pattern after every accepted bit.
- R3: `rx_active` sets only when a second sync completes exactly L bits after a first one. If the character after a first sync is not a sync, the receiver returns to hunting. Neither of the two sync characters is delivered.
- R4: While active, every L accepted bits form one character. The character is loaded into the buffer in the cycle that follows the strobe of its last bit, and `rx_done` sets at the same time.
- R5: With `strip_sync`=1, an active-state character equal to the sync pattern is discarded and leaves the buffer and flags unchanged. With `strip_sync`=0 it is delivered like data.
- R6: `rx_parity` is the XOR of the L data bits of the character in the buffer (even parity).
- R7: A `buf_rd` pulse in a cycle with no character completing clears `rx_done` and `rx_overrun`. When a character completes in the same cycle, the load wins.
- R8: If a character completes while `rx_done` is still set and unread, `rx_overrun` sets and the new character replaces the old one.
- R9: With `half_duplex`=1 and `rts`=1, bit strobes are ignored. Shift state, bit count and framing are all frozen, and reception resumes on the same grid afterwards.
- R10: With `loopback`=1 the receiver samples `tx_serial` instead of `rx_serial`.
- R11: An `active_clr` pulse clears `rx_active` and restarts the sync hunt. No character is delivered until two new syncs are seen.
- R12: After reset, `rx_active`, `rx_done`, `rx_overrun`, `rx_parity` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid serial bit |
| rx_serial | input | 1 | Line receive data |
| tx_serial | input | 1 | Local transmitter output, used in loopback |
| loopback | input | 1 | Select tx_serial as receive source |
| half_duplex | input | 1 | Half-duplex mode enable |
| rts | input | 1 | Request-to-send; inhibits reception in half duplex |
| len_sel | input | 2 | Character length select |
| len_ext | input | 1 | Extended length (adds 4 bits) |
| sync_char | input | 12 | Sync pattern, low L bits used |
| strip_sync | input | 1 | Discard syncs once active |
| active_clr | input | 1 | Pulse: drop active state and restart hunt |
| buf_rd | input | 1 | Pulse: buffer has been read |
| rx_data | output | 12 | Received character, zero above bit L-1 |
| rx_done | output | 1 | Buffer holds an unread character |
| rx_parity | output | 1 | Even parity of buffered character |
| rx_overrun | output | 1 | A character was overwritten before being read |
| rx_active | output | 1 | Receiver synchronized |

## Verification
The bench sweeps all six character lengths, each with sync stripping on and off. Every sync pattern has its top bit set, so a premature match is exposed: a receiver that compared too few bits would go active or frame characters off the grid. A lone sync followed by a non-sync character must leave the receiver hunting, which catches a design that goes active on one sync or on syncs that are not back to back. The bench feeds bits during half-duplex inhibit and then checks that the next character lands exactly where expected; a design that kept counting during the freeze would shift the grid and deliver garbage. The bench also checks overwrite-with-overrun, loopback source selection and restart after clearing the active state, each against values computed in the bench.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int MAXW = 12;
  localparam int CNTW = 4;

  typedef enum logic [1:0] {S_HUNT, S_ONE, S_ACT} fr_state_t;

  // 0,1,2,3 -> 6,7,8,8 ; extended adds four
  function automatic logic [CNTW-1:0] char_len(input logic ext, input logic [1:0] sel);
    logic [CNTW-1:0] base;
    base = (sel == 2'd3) ? CNTW'(8) : CNTW'(6) + CNTW'(sel);
    return ext ? base + CNTW'(4) : base;
  endfunction

  function automatic logic [MAXW-1:0] len_mask(input logic [CNTW-1:0] n);
    logic [MAXW-1:0] m;
    for (int i = 0; i < MAXW; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic even_par(input logic [MAXW-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            rx_serial,
  input  logic            tx_serial,
  input  logic            loopback,
  input  logic            half_duplex,
  input  logic            rts,
  output logic            bit_stb,
  output logic [MAXW-1:0] win_nxt
);
  logic [MAXW-1:0] win_q;
  logic            sel_bit;
  logic            inhibit;

  assign sel_bit = loopback ? tx_serial : rx_serial;
  assign inhibit = half_duplex & rts;
  assign bit_stb = bit_en & ~inhibit;
  assign win_nxt = {win_q[MAXW-2:0], sel_bit};

  always_ff @(posedge clk) begin
    if (!rst_n)       win_q <= '0;
    else if (bit_stb) win_q <= win_nxt;
  end

  // R9
  hd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(win_q));
endmodule

// File: rtl/sync_rx_framer.sv
module sync_rx_framer
  import sync_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_stb,
  input  logic [MAXW-1:0] win_nxt,
  input  logic [CNTW-1:0] len,
  input  logic [MAXW-1:0] mask,
  input  logic [MAXW-1:0] sync_char,
  input  logic            strip_sync,
  input  logic            active_clr,
  output logic            active,
  output logic            char_evt,
  output logic            sync_hit
);
  fr_state_t       state_q;
  logic [CNTW-1:0] cnt_q;
  logic            boundary;

  assign sync_hit = ((win_nxt ^ sync_char) & mask) == '0;
  assign boundary = bit_stb && (state_q != S_HUNT) && (cnt_q >= len - CNTW'(1));
  assign char_evt = boundary && (state_q == S_ACT) && !(strip_sync && sync_hit);
  assign active   = (state_q == S_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n || active_clr) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
    end else if (bit_stb) begin
      unique case (state_q)
        S_HUNT: begin
          cnt_q <= '0;
          if (sync_hit) state_q <= S_ONE;
        end
        S_ONE: begin
          if (boundary) begin
            cnt_q   <= '0;
            state_q <= sync_hit ? S_ACT : S_HUNT;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        default: cnt_q <= boundary ? '0 : cnt_q + CNTW'(1);
      endcase
    end
  end

  // R3
  two_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(state_q) == S_ONE) && $past(sync_hit) && $past(bit_stb));
  // R11
  clr_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_clr |=> !active);
endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer
  import sync_rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXW-1:0] data_in,
  input  logic            buf_rd,
  output logic [MAXW-1:0] data,
  output logic            done,
  output logic            parity,
  output logic            overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0; done <= 1'b0; parity <= 1'b0; overrun <= 1'b0;
    end else if (load) begin
      data   <= data_in;
      parity <= even_par(data_in);
      done   <= 1'b1;
      if (done && !buf_rd) overrun <= 1'b1;
    end else if (buf_rd) begin
      done    <= 1'b0;
      overrun <= 1'b0;
    end
  end

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(load));
  // R8
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(done) && done);
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !load) |=> !done && !overrun);
  // R6
  par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> parity == ($countones(data) % 2 == 1));
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        rx_serial,
  input  logic        tx_serial,
  input  logic        loopback,
  input  logic        half_duplex,
  input  logic        rts,
  input  logic [1:0]  len_sel,
  input  logic        len_ext,
  input  logic [11:0] sync_char,
  input  logic        strip_sync,
  input  logic        active_clr,
  input  logic        buf_rd,
  output logic [11:0] rx_data,
  output logic        rx_done,
  output logic        rx_parity,
  output logic        rx_overrun,
  output logic        rx_active
);
  logic            bit_stb;
  logic [MAXW-1:0] win_nxt;
  logic [CNTW-1:0] len;
  logic [MAXW-1:0] mask;
  logic            char_evt;
  logic            sync_hit;

  assign len  = char_len(len_ext, len_sel);
  assign mask = len_mask(len);

  sync_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_serial(rx_serial),
    .tx_serial(tx_serial), .loopback(loopback), .half_duplex(half_duplex),
    .rts(rts), .bit_stb(bit_stb), .win_nxt(win_nxt));

  sync_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .win_nxt(win_nxt),
    .len(len), .mask(mask), .sync_char(sync_char), .strip_sync(strip_sync),
    .active_clr(active_clr), .active(rx_active), .char_evt(char_evt),
    .sync_hit(sync_hit));

  sync_rx_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .load(char_evt), .data_in(win_nxt & mask),
    .buf_rd(buf_rd), .data(rx_data), .done(rx_done), .parity(rx_parity),
    .overrun(rx_overrun));

  // R5
  strip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_sync && rx_active && bit_stb && sync_hit && !buf_rd) |=> $stable(rx_done) && $stable(rx_data));
endmodule

// File: tb/sync_char_rx_tb.sv
module sync_char_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, rx_serial = 1'b0, tx_serial = 1'b0;
  logic        loopback = 1'b0, half_duplex = 1'b0, rts = 1'b0;
  logic [1:0]  len_sel = 2'd0;
  logic        len_ext = 1'b0;
  logic [11:0] sync_char = '0;
  logic        strip_sync = 1'b0, active_clr = 1'b0, buf_rd = 1'b0;
  logic [11:0] rx_data;
  logic        rx_done, rx_parity, rx_overrun, rx_active;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sync_char_rx u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (loopback) begin tx_serial = b; rx_serial = ~b; end
    else          begin rx_serial = b; tx_serial = ~b; end
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_char(input int val, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(val[i]);
  endtask

  task automatic read_buf();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  function automatic int par_of(input int v);
    int p = 0;
    for (int i = 0; i < 12; i++) p ^= v[i];
    return p;
  endfunction

  task automatic expect_char(input string req, input int d);
    chk({req, " done"}, int'(rx_done), 1);
    chk({req, " data"}, int'(rx_data), d);
    chk({req, " R6 parity"}, int'(rx_parity), par_of(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int li = 0; li < 6; li++) begin
      for (int st = 0; st < 2; st++) begin
        int L, mask, syn, d;
        L    = (li < 3) ? 6 + li : 10 + (li - 3);
        mask = (1 << L) - 1;
        syn  = ((12'hA5B + li * 7) & mask) | (1 << (L - 1));
        len_ext = (li >= 3); len_sel = 2'(li % 3);
        sync_char = 12'(syn) | (12'hFFF & ~12'(mask)); // junk above L, R1
        strip_sync = st[0];
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R12 active", int'(rx_active), 0);
        chk("R12 done", int'(rx_done), 0);
        chk("R12 data", int'(rx_data), 0);
        chk("R12 ovr", int'(rx_overrun), 0);
        // R2/R3: zeros, one sync, non-sync char -> still hunting
        send_char(0, 5);
        send_char(syn, L);
        chk("R3 one sync", int'(rx_active), 0);
        send_char(0, L);
        chk("R3 broken pair", int'(rx_active), 0);
        send_char(syn, L);
        chk("R3 first of pair", int'(rx_active), 0);
        send_char(syn, L);
        chk("R3 pair active", int'(rx_active), 1);
        chk("R3 syncs not delivered", int'(rx_done), 0);
        // R4 / R1 / R6 data characters
        for (int k = 0; k < 3; k++) begin
          d = (k * 149 + li * 23 + 3) & mask;
          if (d == syn) d ^= 1;
          send_char(d, L);
          expect_char("R4 R1", d);
          read_buf();
          chk("R7 read clears done", int'(rx_done), 0);
        end
        // R5 sync while active
        send_char(syn, L);
        if (st == 1) chk("R5 stripped", int'(rx_done), 0);
        else begin expect_char("R5 delivered", syn); read_buf(); end
        // R8 overrun
        d = (li * 41 + 9) & mask; if (d == syn) d ^= 1;
        send_char(d, L);
        chk("R8 no ovr first", int'(rx_overrun), 0);
        d = (d ^ 5) & mask; if (d == syn) d ^= 2;
        send_char(d, L);
        chk("R8 ovr set", int'(rx_overrun), 1);
        expect_char("R8 overwrite", d);
        read_buf();
        chk("R7 ovr cleared", int'(rx_overrun), 0);
        chk("R7 done cleared", int'(rx_done), 0);
        // R9 half duplex inhibit
        half_duplex = 1'b1; rts = 1'b1;
        send_char(mask, L);
        chk("R9 inhibited", int'(rx_done), 0);
        rts = 1'b0;
        d = (li * 77 + 6) & mask; if (d == syn) d ^= 1;
        send_char(d, L);
        expect_char("R9 grid kept", d);
        read_buf();
        half_duplex = 1'b0;
        // R10 loopback
        loopback = 1'b1;
        d = (li * 13 + 10) & mask; if (d == syn) d ^= 1;
        send_char(d, L);
        expect_char("R10 loopback", d);
        loopback = 1'b0;
        read_buf();
        // R11 restart hunt
        @(negedge clk); active_clr = 1'b1;
        @(negedge clk); active_clr = 1'b0;
        chk("R11 cleared", int'(rx_active), 0);
        send_char(d, L);
        chk("R11 hunting no done", int'(rx_done), 0);
        chk("R11 still inactive", int'(rx_active), 0);
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule